// File: doc/BRIEF.md
# Set-Clear Interprocessor Mailbox Bank

The block holds sixteen 32-bit mailbox words that processors use to signal each other. There are four cores, and each core owns four mailboxes. The bank is reached through one simple register port. A sender posts bits with a write-one-to-set access. The receiver reads the word and then acknowledges it with a write-one-to-clear access. While a mailbox holds any nonzero value, the block raises that mailbox's pending line. A separate block routes these lines to the cores' interrupt inputs.

Every port access is classified into exactly one of five operations:

- OP_IDLE: no request, or a write to an unmapped address.
- OP_SET: a write to the set window.
- OP_CLR: a write to the clear window.
- OP_RDMB: a read of the clear window.
- OP_RDZ: a read of the set window or of unmapped space.

The classification is redone on every cycle and carries no memory between accesses. Any operation may follow any other on the next cycle, so every transition between operations is allowed. The result of each access takes effect at the clock edge that samples it.

Top module: `mbx_bank`

## Requirements
- R1: The bank holds 16 mailboxes, four per core. Mailbox index = core*4 + slot. Bit `pending[index]` belongs to mailbox `index`.
- R2: A write to byte address 0x00 + 4*index ORs `wdata` into that mailbox. Address bits [1:0] are ignored.
- R3: A write to byte address 0x40 + 4*index clears every mailbox bit where `wdata` is one. All other bits are kept.
- R4: A read of 0x40 + 4*index returns the mailbox contents on `rdata`, with `rvalid` high, on the cycle after the request.
- R5: A read of the set window (0x00–0x3F) returns zero with `rvalid` high and changes no mailbox.
- R6: `pending[index]` is high exactly when mailbox `index` is nonzero. It follows the update made at the sampling edge.
- R7: A write changes only the addressed mailbox.
- R8: After reset, all mailboxes are zero, `pending` is zero, and `rvalid` and `rdata` are zero.
- R9: Addresses 0x80–0xFF are unmapped. Writes there have no effect, and reads return zero with `rvalid` high.
- R10: Accesses on back-to-back cycles take effect in order.
- R11: `rdata` is zero on any cycle where `rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data (bit mask for set and clear) |
| rdata | output | 32 | Read data, registered |
| rvalid | output | 1 | Read data valid, one cycle after a read |
| pending | output | 16 | Per-mailbox nonzero flag |

## Verification
The bench sweeps every mailbox with walking and overlapping bit patterns. After each access it compares all sixteen pending bits and a read-back of every word against a bench model, which catches:

- an index decode that hits a neighbouring word;
- a set that overwrites instead of ORing;
- a clear that clears the wrong polarity of bits.

Partial clears check that pending stays high until the last bit goes. Reads of the set window and of unmapped space must return zero, and unmapped writes must leave the bank untouched; a decoder that drops the upper address bits would alias those accesses onto real mailboxes. Set-then-clear and clear-then-set on back-to-back cycles expose any swapped or lost update.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    parameter int NCORES    = 4;
    parameter int SLOTS     = 4;
    parameter int DW        = 32;
    parameter int AW        = 8;
    parameter int WIN_BYTES = 64;

    localparam int NMBX    = NCORES * SLOTS;
    localparam int IDX_W   = $clog2(NMBX);
    localparam int WIN_LSB = $clog2(WIN_BYTES);

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_SET,
        OP_CLR,
        OP_RDMB,
        OP_RDZ
    } mbx_op_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
(
    input  logic             req,
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    output mbx_op_e          op,
    output logic [IDX_W-1:0] idx,
    output logic [NMBX-1:0]  set_sel,
    output logic [NMBX-1:0]  clr_sel
);
    localparam int WIN_W = AW - WIN_LSB;

    logic [WIN_W-1:0] win;

    assign win = addr[AW-1:WIN_LSB];
    assign idx = addr[IDX_W+1:2];

    always_comb begin
        op = OP_IDLE;
        unique case ({req, wr})
            2'b11: begin
                if (win == WIN_W'(0))      op = OP_SET;
                else if (win == WIN_W'(1)) op = OP_CLR;
                else                       op = OP_IDLE;
            end
            2'b10: begin
                if (win == WIN_W'(1)) op = OP_RDMB;
                else                  op = OP_RDZ;
            end
            default: op = OP_IDLE;
        endcase
    end

    always_comb begin
        set_sel = '0;
        clr_sel = '0;
        if (op == OP_SET) set_sel[idx] = 1'b1;
        if (op == OP_CLR) clr_sel[idx] = 1'b1;
    end

    // R7: one access selects at most one mailbox
    assert_one_target_R7: assert property (@(posedge req)
        $onehot0(set_sel | clr_sel));
    assert_comb_one_R7: assert final ($onehot0(set_sel | clr_sel));
endmodule

// File: rtl/mbx_word.sv
module mbx_word
    import mbx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic          clr_en,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (set_en) q <= q | mask;
        else if (clr_en) q <= q & ~mask;
    end

    assert_set_or_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(set_en) |-> q == ($past(q) | $past(mask)));

    assert_clr_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_en) && !$past(set_en) |-> q == ($past(q) & ~$past(mask)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(set_en) && !$past(clr_en) |-> $stable(q));
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
    import mbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             rvalid,
    output logic [NMBX-1:0]  pending
);
    mbx_op_e          op;
    logic [IDX_W-1:0] idx;
    logic [NMBX-1:0]  set_sel;
    logic [NMBX-1:0]  clr_sel;
    logic [DW-1:0]    words [NMBX];

    mbx_decode u_dec (
        .req     (req),
        .wr      (wr),
        .addr    (addr),
        .op      (op),
        .idx     (idx),
        .set_sel (set_sel),
        .clr_sel (clr_sel)
    );

    for (genvar i = 0; i < NMBX; i++) begin : g_mbx
        mbx_word u_word (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (set_sel[i]),
            .clr_en (clr_sel[i]),
            .mask   (wdata),
            .q      (words[i])
        );
        assign pending[i] = |words[i];
    end

    // Read response register: the output process keyed on the decoded operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            unique case (op)
                OP_RDMB: begin
                    rvalid <= 1'b1;
                    rdata  <= words[idx];
                end
                OP_RDZ: begin
                    rvalid <= 1'b1;
                    rdata  <= '0;
                end
                default: begin
                    rvalid <= 1'b0;
                    rdata  <= '0;
                end
            endcase
        end
    end

    assert_unmapped_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req && wr && addr[AW-1]) |-> pending == $past(pending));

    assert_rd_nochange_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req && !wr) |-> pending == $past(pending));

    assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> rdata == '0);

    assert_rvalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req && !wr) |-> rvalid);
endmodule

// File: tb/mbx_bank_test.sv
`timescale 1ns/1ps
module mbx_bank_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        req = 0;
    logic        wr = 0;
    logic [7:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic        rvalid;
    logic [15:0] pending;

    int total = 0;
    int bad = 0;
    logic [31:0] model [16];

    always #2.5 clk = ~clk;

    mbx_bank uut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .pending(pending)
    );

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_pend();
        logic [15:0] p = '0;
        for (int i = 0; i < 16; i++) p[i] = (model[i] != 0);
        return p;
    endfunction

    function automatic void model_wr(logic [7:0] a, logic [31:0] d);
        if (a < 8'h40)      model[a[5:2]] = model[a[5:2]] | d;
        else if (a < 8'h80) model[a[5:2]] = model[a[5:2]] & ~d;
    endfunction

    task automatic do_wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        req = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk);
        req = 0; wr = 0;
        model_wr(a, d);
    endtask

    task automatic do_rd(logic [7:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        req = 1; wr = 0; addr = a; wdata = 0;
        @(negedge clk);
        req = 0;
        d = rdata; v = rvalid;
    endtask

    task automatic check_all(string tag);
        logic [31:0] d;
        logic v;
        chk({tag, " R6 pending"}, 32'(pending), 32'(exp_pend()));
        for (int i = 0; i < 16; i++) begin
            do_rd(8'h40 + 8'(i*4), d, v);
            chk({tag, " R4 rvalid"}, 32'(v), 32'd1);
            chk({tag, " R4 R7 data"}, d, model[i]);
        end
    endtask

    initial begin
        logic [31:0] d;
        logic v;
        for (int i = 0; i < 16; i++) model[i] = 0;

        #12 rst_n = 1;
        @(negedge clk);
        chk("R8 pending", 32'(pending), 0);
        chk("R8 rvalid", 32'(rvalid), 0);
        chk("R11 rdata idle", rdata, 0);
        check_all("R8 reset");

        // R2 / R1: set each mailbox with an index-dependent pattern
        for (int i = 0; i < 16; i++) begin
            do_wr(8'(i*4), 32'h1 << i);
            chk("R1 R6 pending after set", 32'(pending), 32'(exp_pend()));
        end
        for (int i = 0; i < 16; i++) do_wr(8'(i*4) | 8'(i % 4), 32'hA5000000 ^ (32'(i) << 8));
        check_all("R2 or-set");

        // R3: partial clears, pending must stay until last bit goes
        for (int i = 0; i < 16; i++) begin
            do_wr(8'h40 + 8'(i*4), 32'hA5000000 ^ (32'(i) << 8));
            chk("R3 R6 partial clear pending", 32'(pending[i]), 32'(model[i] != 0));
            do_wr(8'h40 + 8'(i*4), 32'hFFFF_FFFF);
            chk("R3 full clear pending", 32'(pending[i]), 0);
        end
        check_all("R3 clear");

        // R5: reads of set window return zero and change nothing
        do_wr(8'h14, 32'h0000_00F0);
        for (int i = 0; i < 16; i++) begin
            do_rd(8'(i*4), d, v);
            chk("R5 set-window read", d, 0);
            chk("R5 rvalid", 32'(v), 1);
        end
        chk("R5 pending unchanged", 32'(pending), 32'(exp_pend()));

        // R9: unmapped space
        for (int a = 8'h80; a < 256; a += 12) begin
            do_wr(8'(a), 32'hFFFF_FFFF);
            do_rd(8'(a), d, v);
            chk("R9 unmapped read", d, 0);
            chk("R9 unmapped rvalid", 32'(v), 1);
        end
        check_all("R9 unmapped write");

        // R11: idle cycle after read
        @(negedge clk);
        chk("R11 rdata idle", rdata, 0);

        // R10: back-to-back set then clear, and clear then set
        @(negedge clk);
        req = 1; wr = 1; addr = 8'h08; wdata = 32'h0000_FF00;
        @(negedge clk);
        addr = 8'h48; wdata = 32'h0000_0F00;
        @(negedge clk);
        addr = 8'h48; wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        addr = 8'h08; wdata = 32'h0000_0003;
        @(negedge clk);
        wr = 0; addr = 8'h48;
        @(negedge clk);
        req = 0;
        model[2] = 32'h0000_0003;
        chk("R10 b2b read", rdata, 32'h0000_0003);
        chk("R10 b2b pending", 32'(pending), 32'(exp_pend()));
        check_all("R10 final");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule